// File: doc/BRIEF.md
# Shared Second-Level Cache Tag Controller with Read-Only Alias Policy

This block holds the tags and line states for a 4-way set-associative unified second-level cache that two cores share. The cache is indexed by physical line address and has 128-byte lines. A lookup is accepted at most every other cycle. Its hit or miss result comes out a fixed 8 cycles later. A read miss is passed to the memory side. A read hit is counted against a budget of hits that the data array still has to serve. Instruction misses are limited for each core. The data array, the memory interface and the bus side sit outside the block. They tell it when work finishes through single-cycle completion pulses.

Lines are written into the tag store only at two points: when a first-level cache evicts a private line, and when a line comes back from memory toward a core. The store does not keep copies of the first-level lines. The victim way is chosen at write time. An invalid way is taken first. If there is none, a round-robin pointer kept for each set picks the way, and a dirty victim produces a writeback request. Three configuration inputs control aliasing on pages marked read-only:

- one turns private-clean memory returns into shared lines;
- one stores private-clean evictions as shared lines;
- one forces data flushes on read-only pages, or in real mode, out to the bus even when they hit.

Top module: `l2tag_ctrl`

## Requirements
- R1: After reset every line is invalid (state code 0), all result, miss, flush and writeback outputs are low, and `req_ready` is high for a data read.
- R2: A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after an accepting edge. The result (`res_valid` with `res_hit`, `res_way`, `res_state`, `res_core`) is visible in the cycle after the 8th edge following acceptance.
- R3: State codes are 0 invalid, 1 instruction, 2 shared, 3 private clean, 4 private dirty. Operation codes are 0 data read, 1 instruction fetch, and 2 or 3 data flush. A data read or data flush hits a matching line in state 2, 3 or 4. An instruction fetch hits a matching line in state 1 or 2. On a hit, `res_way` and `res_state` report the line. On a miss they report 0.
- R4: A read or fetch that misses raises `miss_valid` together with its result.
- R5: A read or fetch is refused while outstanding hits plus in-flight reads and fetches reach 8. A read or fetch hit adds one outstanding hit. A `hit_done` pulse removes one.
- R6: An instruction fetch from a core is refused while that core's outstanding instruction misses plus its in-flight fetches reach 4. An instruction miss adds one for its core. An `imiss_done` pulse removes one for `imiss_done_core`. The other core is not affected.
- R7: A write with `wr_evict`=1 stores state 3 or 4. A write with `wr_evict`=0 stores state 1 or 2. Any other write leaves the store unchanged. A write whose line is already present, in any state, replaces that line's state in place.
- R8: A write of a new line uses the lowest-numbered invalid way. If the set is full, it uses the set's round-robin pointer, which starts at 0 and advances by one on each replacement. Replacing a state-4 line raises `wb_valid` with the victim's line address in the next cycle.
- R9: With `cfg_ro_en` set, a memory return in state 3 with `wr_ro` set is stored as state 2. Without it, such a return is not stored.
- R10: With `cfg_ro_block` set, an eviction in state 3 with `wr_ro` set is stored as state 2.
- R11: A data flush that hits invalidates the line, and raises `wb_valid` for that line if it was in state 4. `flush_bus` goes high with the flush's result when the flush missed, or when `cfg_ro_bcast` is set and the flush carried `req_ro` or `req_real`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ro_en | input | 1 | Turn private-clean returns on read-only pages into shared lines |
| cfg_ro_block | input | 1 | Store private-clean evictions on read-only pages as shared lines |
| cfg_ro_bcast | input | 1 | Force read-only or real-mode data flushes to the bus |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted this cycle (depends on `req_op` and `req_core`) |
| req_op | input | 2 | 0 data read, 1 instruction fetch, 2 or 3 data flush |
| req_core | input | 1 | Requesting core |
| req_line | input | 37 | Physical line address (byte address without offset bits) |
| req_ro | input | 1 | Request targets a read-only page |
| req_real | input | 1 | Flush issued in real mode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 2 | Way that hit |
| res_state | output | 3 | State of the line that hit |
| res_core | output | 1 | Core of the request being reported |
| miss_valid | output | 1 | Read or fetch miss sent to the memory side |
| flush_bus | output | 1 | Flush sent to the bus |
| hit_done | input | 1 | Data array finished one queued hit |
| imiss_done | input | 1 | One instruction miss completed |
| imiss_done_core | input | 1 | Core whose instruction miss completed |
| wr_valid | input | 1 | Line write request |
| wr_evict | input | 1 | 1 eviction from the first-level cache, 0 return from memory |
| wr_line | input | 37 | Line address being written |
| wr_state | input | 3 | State offered with the write |
| wr_ro | input | 1 | Written line is on a read-only page |
| wb_valid | output | 1 | Writeback of a dirty line requested |
| wb_line | output | 37 | Line address to write back |

## Verification
The checks assume three things about the inputs. `hit_done` pulses only while hits are outstanding. `imiss_done` names only a core with an instruction miss still open. No line write arrives on the same edge as a flush result, so an invalidation and a fill never meet, and two writebacks never compete for one cycle. The stimulus keeps to these rules by asking its own behavioural model before it drives each cycle. It only sends completion pulses the model can account for, and it holds off writes in any cycle where the model has a flush result due. Requests are driven without regard to `req_ready`, so refused lookups are simply dropped, which pushes the hit budget and the per-core instruction limit to their edges.

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl #(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int ADDR_W     = 44,
  parameter int LINE_BYTES = 128,
  parameter int LAT        = 8,
  parameter int MAX_HITS   = 8,
  parameter int MAX_IMISS  = 4
)(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ro_en,
  input  logic cfg_ro_block,
  input  logic cfg_ro_bcast,
  input  logic req_valid,
  output logic req_ready,
  input  logic [1:0] req_op,
  input  logic req_core,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] req_line,
  input  logic req_ro,
  input  logic req_real,
  output logic res_valid,
  output logic res_hit,
  output logic [$clog2(WAYS)-1:0] res_way,
  output logic [2:0] res_state,
  output logic res_core,
  output logic miss_valid,
  output logic flush_bus,
  input  logic hit_done,
  input  logic imiss_done,
  input  logic imiss_done_core,
  input  logic wr_valid,
  input  logic wr_evict,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wr_line,
  input  logic [2:0] wr_state,
  input  logic wr_ro,
  output logic wb_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wb_line
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int HC_W   = $clog2(MAX_HITS + 1);
  localparam int IC_W   = $clog2(MAX_IMISS + 1);

  localparam logic [2:0] S_INV = 3'd0;
  localparam logic [2:0] S_INS = 3'd1;
  localparam logic [2:0] S_SHR = 3'd2;
  localparam logic [2:0] S_PCL = 3'd3;
  localparam logic [2:0] S_PDY = 3'd4;
  localparam logic [1:0] OP_IF = 2'd1;

  function automatic logic eligible(input logic [1:0] op, input logic [2:0] st);
    if (op == OP_IF) return (st == S_INS) || (st == S_SHR);
    return (st == S_SHR) || (st == S_PCL) || (st == S_PDY);
  endfunction

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [2:0]       st_q  [SETS][WAYS];
  logic [WAY_W-1:0] ptr_q [SETS];

  logic              p_v    [LAT];
  logic [1:0]        p_op   [LAT];
  logic              p_core [LAT];
  logic [LINE_W-1:0] p_line [LAT];
  logic              p_ro   [LAT];
  logic              p_real [LAT];

  logic gap_q;
  logic [HC_W-1:0] hits_q;
  logic [IC_W-1:0] imiss_q0, imiss_q1;

  wire acc = req_valid && req_ready;

  int infl_rd, infl_if0, infl_if1;
  always_comb begin
    infl_rd = 0;
    infl_if0 = 0;
    infl_if1 = 0;
    for (int i = 0; i < LAT; i++) begin
      if (p_v[i] && !p_op[i][1]) infl_rd = infl_rd + 1;
      if (p_v[i] && p_op[i] == OP_IF) begin
        if (p_core[i]) infl_if1 = infl_if1 + 1;
        else           infl_if0 = infl_if0 + 1;
      end
    end
  end

  wire is_flush = req_op[1];
  wire is_if    = (req_op == OP_IF);
  wire if_room  = req_core ? (int'(imiss_q1) + infl_if1 < MAX_IMISS)
                           : (int'(imiss_q0) + infl_if0 < MAX_IMISS);
  assign req_ready = !gap_q && (is_flush || (int'(hits_q) + infl_rd < MAX_HITS))
                     && (!is_if || if_room);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) p_v[i] <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      p_v[0] <= acc;
      for (int i = 1; i < LAT; i++) p_v[i] <= p_v[i-1];
      gap_q <= acc;
    end
  end

  always_ff @(posedge clk) begin
    p_op[0]   <= req_op;
    p_core[0] <= req_core;
    p_line[0] <= req_line;
    p_ro[0]   <= req_ro;
    p_real[0] <= req_real;
    for (int i = 1; i < LAT; i++) begin
      p_op[i]   <= p_op[i-1];
      p_core[i] <= p_core[i-1];
      p_line[i] <= p_line[i-1];
      p_ro[i]   <= p_ro[i-1];
      p_real[i] <= p_real[i-1];
    end
  end

  wire              lk_v    = p_v[LAT-1];
  wire [1:0]        lk_op   = p_op[LAT-1];
  wire [LINE_W-1:0] lk_line = p_line[LAT-1];
  wire [IDX_W-1:0]  lk_idx  = lk_line[IDX_W-1:0];
  wire [TAG_W-1:0]  lk_tag  = lk_line[LINE_W-1:IDX_W];

  logic lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic [2:0] lk_st;
  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    lk_st  = S_INV;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_q[lk_idx][w] != S_INV && tag_q[lk_idx][w] == lk_tag &&
          eligible(lk_op, st_q[lk_idx][w])) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(w);
        lk_st  = st_q[lk_idx][w];
      end
    end
  end

  wire fl_do = lk_v && lk_op[1] && lk_hit;

  wire [IDX_W-1:0] w_idx = wr_line[IDX_W-1:0];
  wire [TAG_W-1:0] w_tag = wr_line[LINE_W-1:IDX_W];

  logic w_match, w_inv;
  logic [WAY_W-1:0] w_mway, w_iway;
  always_comb begin
    w_match = 1'b0;
    w_inv   = 1'b0;
    w_mway  = '0;
    w_iway  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_q[w_idx][w] != S_INV && tag_q[w_idx][w] == w_tag) begin
        w_match = 1'b1;
        w_mway  = WAY_W'(w);
      end
      if (st_q[w_idx][w] == S_INV) begin
        w_inv  = 1'b1;
        w_iway = WAY_W'(w);
      end
    end
  end

  logic [2:0] w_eff;
  always_comb begin
    w_eff = S_INV;
    if (wr_evict) begin
      if (wr_state == S_PDY)      w_eff = S_PDY;
      else if (wr_state == S_PCL) w_eff = (wr_ro && cfg_ro_block) ? S_SHR : S_PCL;
    end else begin
      if (wr_state == S_SHR || wr_state == S_INS)     w_eff = wr_state;
      else if (wr_state == S_PCL && wr_ro && cfg_ro_en) w_eff = S_SHR;
    end
  end

  wire [WAY_W-1:0] w_vic = w_match ? w_mway : (w_inv ? w_iway : ptr_q[w_idx]);
  wire w_do   = wr_valid && (w_eff != S_INV);
  wire w_repl = w_do && !w_match && !w_inv;
  wire w_wb   = w_repl && (st_q[w_idx][w_vic] == S_PDY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= S_INV;
      end
    end else begin
      if (fl_do)  st_q[lk_idx][lk_way] <= S_INV;
      if (w_do)   st_q[w_idx][w_vic] <= w_eff;
      if (w_repl) ptr_q[w_idx] <= w_vic + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (w_do) tag_q[w_idx][w_vic] <= w_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_way    <= '0;
      res_state  <= S_INV;
      res_core   <= 1'b0;
      miss_valid <= 1'b0;
      flush_bus  <= 1'b0;
      wb_valid   <= 1'b0;
      wb_line    <= '0;
    end else begin
      res_valid  <= lk_v;
      res_hit    <= lk_v && lk_hit;
      res_way    <= lk_v ? lk_way : '0;
      res_state  <= lk_v ? lk_st : S_INV;
      res_core   <= lk_v && p_core[LAT-1];
      miss_valid <= lk_v && !lk_op[1] && !lk_hit;
      flush_bus  <= lk_v && lk_op[1] &&
                    (!lk_hit || (cfg_ro_bcast && (p_ro[LAT-1] || p_real[LAT-1])));
      wb_valid   <= w_wb || (fl_do && lk_st == S_PDY);
      wb_line    <= w_wb ? {tag_q[w_idx][w_vic], w_idx} : lk_line;
    end
  end

  wire hit_inc = lk_v && !lk_op[1] && lk_hit;
  wire hit_dec = hit_done && (hits_q != '0);
  wire im_inc0 = lk_v && lk_op == OP_IF && !lk_hit && !p_core[LAT-1];
  wire im_inc1 = lk_v && lk_op == OP_IF && !lk_hit &&  p_core[LAT-1];
  wire im_dec0 = imiss_done && !imiss_done_core && (imiss_q0 != '0);
  wire im_dec1 = imiss_done &&  imiss_done_core && (imiss_q1 != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q   <= '0;
      imiss_q0 <= '0;
      imiss_q1 <= '0;
    end else begin
      hits_q   <= hits_q + HC_W'(hit_inc) - HC_W'(hit_dec);
      imiss_q0 <= imiss_q0 + IC_W'(im_inc0) - IC_W'(im_dec0);
      imiss_q1 <= imiss_q1 + IC_W'(im_inc1) - IC_W'(im_dec1);
    end
  end
endmodule

// File: rtl/l2tag_ctrl_chk.sv
module l2tag_ctrl_chk #(
  parameter int LAT       = 8,
  parameter int MAX_HITS  = 8,
  parameter int MAX_IMISS = 4,
  parameter int HC_W      = 4,
  parameter int IC_W      = 3
)(
  input logic clk,
  input logic rst_n,
  input logic acc,
  input logic res_valid,
  input logic res_hit,
  input logic miss_valid,
  input logic [2:0] res_state,
  input logic [HC_W-1:0] hits,
  input logic [IC_W-1:0] im0,
  input logic [IC_W-1:0] im1
);
  logic [LAT-1:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAT-2:0], acc};
  end

  assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n) acc |=> !acc);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n) sh[LAT-1] |=> res_valid);
  assert_no_early_R2: assert property (@(posedge clk) disable iff (!rst_n) !sh[LAT-1] |=> !res_valid);
  assert_hit_state_R3: assert property (@(posedge clk) disable iff (!rst_n) res_hit |-> res_state != 3'd0);
  assert_miss_R4: assert property (@(posedge clk) disable iff (!rst_n) miss_valid |-> (res_valid && !res_hit));
  assert_hit_limit_R5: assert property (@(posedge clk) disable iff (!rst_n) int'(hits) <= MAX_HITS);
  assert_imiss_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(im0) <= MAX_IMISS) && (int'(im1) <= MAX_IMISS));
endmodule

bind l2tag_ctrl l2tag_ctrl_chk #(
  .LAT(LAT), .MAX_HITS(MAX_HITS), .MAX_IMISS(MAX_IMISS), .HC_W(HC_W), .IC_W(IC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .res_valid(res_valid), .res_hit(res_hit),
  .miss_valid(miss_valid), .res_state(res_state), .hits(hits_q),
  .im0(imiss_q0), .im1(imiss_q1)
);

// File: tb/l2tag_ctrl_test.sv
`timescale 1ns/1ps
module l2tag_ctrl_test;
  localparam int LINE_W = 37;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ro_en = 0, cfg_ro_block = 0, cfg_ro_bcast = 0;
  logic req_valid = 0, req_core = 0, req_ro = 0, req_real = 0;
  logic [1:0] req_op = 0;
  logic [LINE_W-1:0] req_line = '0;
  logic hit_done = 0, imiss_done = 0, imiss_done_core = 0;
  logic wr_valid = 0, wr_evict = 0, wr_ro = 0;
  logic [LINE_W-1:0] wr_line = '0;
  logic [2:0] wr_state = 0;
  logic req_ready, res_valid, res_hit, res_core, miss_valid, flush_bus, wb_valid;
  logic [1:0] res_way;
  logic [2:0] res_state;
  logic [LINE_W-1:0] wb_line;

  always #10 clk = ~clk;

  l2tag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_ro_en(cfg_ro_en), .cfg_ro_block(cfg_ro_block),
    .cfg_ro_bcast(cfg_ro_bcast), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_core(req_core), .req_line(req_line), .req_ro(req_ro),
    .req_real(req_real), .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
    .res_state(res_state), .res_core(res_core), .miss_valid(miss_valid),
    .flush_bus(flush_bus), .hit_done(hit_done), .imiss_done(imiss_done),
    .imiss_done_core(imiss_done_core), .wr_valid(wr_valid), .wr_evict(wr_evict),
    .wr_line(wr_line), .wr_state(wr_state), .wr_ro(wr_ro), .wb_valid(wb_valid),
    .wb_line(wb_line)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    int op; bit core; logic [LINE_W-1:0] line; bit ro; bit rl; int due;
  } ent_t;

  int m_st [64][4];
  logic [30:0] m_tag [64][4];
  int m_ptr [64];
  ent_t q[$];
  int cyc, hits, im0, im1;
  bit gap;
  bit e_rv, e_rh, e_core, e_miss, e_fb, e_wb;
  int e_way, e_st;
  logic [LINE_W-1:0] e_wbl;

  function automatic bit okst(int op, int st);
    if (op == 1) return st == 1 || st == 2;
    return st >= 2 && st <= 4;
  endfunction

  function automatic bit m_ready();
    int rd = 0, f0 = 0, f1 = 0;
    foreach (q[k]) begin
      if (q[k].op < 2) rd++;
      if (q[k].op == 1) begin
        if (q[k].core) f1++; else f0++;
      end
    end
    if (gap) return 0;
    if (req_op < 2 && hits + rd >= 8) return 0;
    if (req_op == 1 && (req_core ? im1 + f1 : im0 + f0) >= 4) return 0;
    return 1;
  endfunction

  ent_t e;
  bit acc_m, fl, wdo, wrep, wwb;
  int hw, fl_ix, fl_w, fl_st, eff, ix, mw, iw, vic;
  logic [30:0] tg;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_st[s, w]) m_st[s][w] = 0;
      foreach (m_ptr[s]) m_ptr[s] = 0;
      q.delete();
      cyc = 0; hits = 0; im0 = 0; im1 = 0; gap = 0;
      e_rv = 0; e_rh = 0; e_core = 0; e_miss = 0; e_fb = 0; e_wb = 0;
      e_way = 0; e_st = 0; e_wbl = '0;
    end else begin
      acc_m = req_valid && m_ready();
      e_rv = 0; e_rh = 0; e_core = 0; e_miss = 0; e_fb = 0; e_wb = 0;
      e_way = 0; e_st = 0; fl = 0;
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        ix = int'(e.line[5:0]);
        tg = e.line[36:6];
        hw = -1;
        for (int w = 0; w < 4; w++)
          if (m_st[ix][w] != 0 && m_tag[ix][w] == tg && okst(e.op, m_st[ix][w])) hw = w;
        e_rv = 1; e_core = e.core;
        if (hw >= 0) begin e_rh = 1; e_way = hw; e_st = m_st[ix][hw]; end
        if (e.op < 2) begin
          if (hw < 0) e_miss = 1;
          else hits++;
          if (e.op == 1 && hw < 0) begin if (e.core) im1++; else im0++; end
        end else begin
          e_fb = (hw < 0) || (cfg_ro_bcast && (e.ro || e.rl));
          if (hw >= 0) begin fl = 1; fl_ix = ix; fl_w = hw; fl_st = m_st[ix][hw]; end
        end
      end
      if (hit_done && hits > 0) hits--;
      if (imiss_done) begin
        if (imiss_done_core && im1 > 0) im1--;
        if (!imiss_done_core && im0 > 0) im0--;
      end
      wdo = 0; wrep = 0; wwb = 0; eff = 0;
      if (wr_valid) begin
        if (wr_evict) begin
          if (wr_state == 4) eff = 4;
          else if (wr_state == 3) eff = (wr_ro && cfg_ro_block) ? 2 : 3;
        end else begin
          if (wr_state == 1 || wr_state == 2) eff = wr_state;
          else if (wr_state == 3 && wr_ro && cfg_ro_en) eff = 2;
        end
      end
      if (eff != 0) begin
        wdo = 1;
        ix = int'(wr_line[5:0]); tg = wr_line[36:6];
        mw = -1; iw = -1;
        for (int w = 3; w >= 0; w--) begin
          if (m_st[ix][w] != 0 && m_tag[ix][w] == tg) mw = w;
          if (m_st[ix][w] == 0) iw = w;
        end
        if (mw >= 0) vic = mw;
        else if (iw >= 0) vic = iw;
        else begin vic = m_ptr[ix]; wrep = 1; end
        if (wrep && m_st[ix][vic] == 4) begin
          wwb = 1; e_wbl = {m_tag[ix][vic], 6'(ix)};
        end
      end
      if (fl) begin
        m_st[fl_ix][fl_w] = 0;
        if (fl_st == 4 && !wwb) begin wwb = 1; e_wbl = e.line; end
      end
      if (wdo) begin
        m_st[ix][vic] = eff; m_tag[ix][vic] = tg;
        if (wrep) m_ptr[ix] = (m_ptr[ix] + 1) % 4;
      end
      e_wb = wwb;
      if (acc_m) q.push_back('{op: int'(req_op), core: req_core, line: req_line,
                               ro: req_ro, rl: req_real, due: cyc + LAT});
      gap = acc_m;
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(req_ready == m_ready(), "R2 R5 R6 req_ready", req_ready, m_ready());
      chk(res_valid == e_rv, "R2 res_valid", res_valid, e_rv);
      if (e_rv) begin
        chk(res_hit == e_rh, "R3 res_hit", res_hit, e_rh);
        chk(int'(res_state) == e_st, "R3 R7 R9 R10 res_state", res_state, e_st);
        chk(int'(res_way) == e_way, "R3 R8 res_way", res_way, e_way);
        chk(res_core == e_core, "R2 res_core", res_core, e_core);
      end
      chk(miss_valid == e_miss, "R4 miss_valid", miss_valid, e_miss);
      chk(flush_bus == e_fb, "R11 flush_bus", flush_bus, e_fb);
      chk(wb_valid == e_wb, "R8 R11 wb_valid", wb_valid, e_wb);
      if (e_wb) chk(wb_line == e_wbl, "R8 R11 wb_line", wb_line, e_wbl);
    end
  end

  function automatic logic [LINE_W-1:0] pick();
    logic [5:0] ixv;
    case ($urandom_range(2))
      0: ixv = 6'd0;
      1: ixv = 6'd1;
      default: ixv = 6'd63;
    endcase
    return {31'($urandom_range(5)), ixv};
  endfunction

  task automatic run_phase(int n, int preq, int pwr, int phd, int pid, bit [2:0] cfg);
    cfg_ro_en = cfg[0]; cfg_ro_block = cfg[1]; cfg_ro_bcast = cfg[2];
    repeat (n) begin
      @(posedge clk); #2;
      req_valid = ($urandom_range(99) < preq);
      req_op = 2'($urandom_range(3));
      req_core = 1'($urandom_range(1));
      req_line = pick();
      req_ro = ($urandom_range(99) < 40);
      req_real = ($urandom_range(99) < 20);
      hit_done = (hits > 0) && ($urandom_range(99) < phd);
      imiss_done = 0;
      if ($urandom_range(99) < pid) begin
        imiss_done_core = 1'($urandom_range(1));
        if (imiss_done_core && im1 > 0) imiss_done = 1;
        if (!imiss_done_core && im0 > 0) imiss_done = 1;
      end
      wr_valid = ($urandom_range(99) < pwr) &&
                 !(q.size() > 0 && q[0].due == cyc && q[0].op >= 2);
      wr_evict = 1'($urandom_range(1));
      wr_line = pick();
      wr_state = 3'($urandom_range(4));
      wr_ro = ($urandom_range(99) < 50);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    chk(miss_valid == 1'b0 && flush_bus == 1'b0, "R1 miss/flush after reset",
        {miss_valid, flush_bus}, 0);
    chk(wb_valid == 1'b0, "R1 wb_valid after reset", wb_valid, 0);
    run_phase(2500, 60, 40, 50, 50, 3'b000);
    run_phase(2500, 70, 45, 10, 30, 3'b111);
    run_phase(2500, 50, 50, 40, 5, 3'b110);
    run_phase(2500, 60, 30, 60, 60, 3'b101);
    run_phase(1000, 0, 0, 90, 90, 3'b000);
    @(posedge clk); #2;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired R2 actual=%0d expected=%0d", cyc, 11000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule